// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast clock by a programmable integer N = M·P + S. A dual-modulus prescaler divides the fast clock by M+1 or by M, where M is a build-time parameter. Two counters, a program counter loaded with P and a swallow counter loaded with S, count the prescaler's output ticks. Each output period opens with the prescaler at M+1 and both counters running. After S ticks the swallow counter is full, the modulus control drops, and the prescaler divides by M. The program counter alone runs on to P ticks. It then ends the period with a one-cycle output pulse and restarts both counters.

P and S are taken from the ports only at the end of each period, so a new setting never produces a cut-short period. A combinational error flag warns when the setting cannot give M·P + S. That happens when S exceeds P or when P is zero. Every integer ratio from M·(M−1) upward can be reached.

Top module: `pswallow_div`

## Requirements
- R1: While rst_n is low, div_pulse and mod_ctrl are 0.
- R2: The prescaler divides by M+1 while mod_ctrl is 1 and by M while mod_ctrl is 0. With S = 0 the output period is therefore M·P cycles, and with S = P it is (M+1)·P cycles.
- R3: When 1 ≤ P and S ≤ P, mod_ctrl is 1 for exactly S·(M+1) clk cycles, counted from the cycle in which div_pulse is high, and is 0 for the rest of the period.
- R4: When 1 ≤ P and S ≤ P, consecutive div_pulse highs are exactly M·P + S clk cycles apart.
- R5: div_pulse is high for exactly one clk cycle per period.
- R6: prog_p and swal_s are sampled only at the clock edge that raises div_pulse. A change made after a pulse leaves the running period at the old ratio, and the following period uses the new one.
- R7: cfg_err is 1 in the same cycle whenever swal_s > prog_p or prog_p = 0, and 0 otherwise.
- R8: When S > P ≥ 1, the period is (M+1)·P cycles and mod_ctrl stays 1 for the whole period.
- R9: Every ratio N ≥ M·(M−1) is produced with P = N div M and S = N mod M. For M = 2, P = 6 and S = 4, mod_ctrl is high for 12 cycles and the period is 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_p | input | CNT_W | Program count P |
| swal_s | input | CNT_W | Swallow count S |
| div_pulse | output | 1 | One-cycle pulse per divided period |
| mod_ctrl | output | 1 | 1 selects divide by M+1, 0 selects divide by M |
| cfg_err | output | 1 | Setting cannot give M·P+S (S > P or P = 0) |

## Verification
Two events can land on the same prescaler tick: the last program-counter tick that ends the period and reloads the setting, and the tick on which the swallow counter fills and drops the modulus control. The bench provokes this with S = P. In that case the drop and the end of the period coincide, and mod_ctrl must stay high for the full (M+1)·P cycles and then start high again in the next period. It also provokes it with S > P, where the reload must win over a swallow count that is never reached. Both cases are judged from the measured interval between pulses and from the count of mod_ctrl-high cycles, and the same is done with the setting changed right after a pulse, so that the reload edge and a pending change meet.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_PLUS = 1'b1
  } psd_mod_e;
endpackage

// File: rtl/psd_rst_sync.sv
module psd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int M = 4
) (
  input  logic     clk,
  input  logic     arst_n,
  input  logic     en,
  input  psd_mod_e mod_sel,
  output logic     tick
);
  localparam int PW = $clog2(M + 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic [PW-1:0] last;

  always_comb begin
    last  = (mod_sel == MOD_PLUS) ? PW'(M) : PW'(M - 1);
    tick  = en && (cnt_q == last);
    cnt_d = cnt_q;
    if (en) cnt_d = tick ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2
  pre_base_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mod_sel == MOD_BASE) |-> (cnt_q < PW'(M)));
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
  import psd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] s_lat,
  output psd_mod_e         mod_sel
);
  logic [CNT_W-1:0] sw_q;
  logic [CNT_W-1:0] sw_d;
  logic             busy;

  always_comb begin
    busy    = (sw_q < s_lat);
    mod_sel = busy ? MOD_PLUS : MOD_BASE;
    sw_d    = sw_q;
    if (clr)               sw_d = '0;
    else if (tick && busy) sw_d = sw_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sw_q <= '0;
    else         sw_q <= sw_d;
  end

  // R3
  sw_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
    sw_q <= s_lat);
endmodule

// File: rtl/psd_program_ctr.sv
module psd_program_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] p_lat,
  output logic             pg_last
);
  logic [CNT_W-1:0] pg_q;
  logic [CNT_W-1:0] pg_d;

  always_comb begin
    pg_last = tick && (pg_q == (p_lat - CNT_W'(1)));
    pg_d    = pg_q;
    if (clr)       pg_d = '0;
    else if (tick) pg_d = pg_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pg_q <= '0;
    else         pg_q <= pg_d;
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import psd_pkg::*;
#(
  parameter int M     = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prog_p,
  input  logic [CNT_W-1:0] swal_s,
  output logic             div_pulse,
  output logic             mod_ctrl,
  output logic             cfg_err
);
  logic             arst_n;
  logic             boot_q;
  logic             load;
  logic             pre_tick;
  logic             eoc;
  logic             pulse_q;
  logic [CNT_W-1:0] p_lat_q, p_lat_d;
  logic [CNT_W-1:0] s_lat_q, s_lat_d;
  psd_mod_e         mod_sel;

  psd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(arst_n)
  );

  psd_prescaler #(.M(M)) u_pre (
    .clk(clk), .arst_n(arst_n), .en(!boot_q), .mod_sel(mod_sel), .tick(pre_tick)
  );

  psd_swallow_ctr #(.CNT_W(CNT_W)) u_swc (
    .clk(clk), .arst_n(arst_n), .tick(pre_tick), .clr(load),
    .s_lat(s_lat_q), .mod_sel(mod_sel)
  );

  psd_program_ctr #(.CNT_W(CNT_W)) u_pgc (
    .clk(clk), .arst_n(arst_n), .tick(pre_tick), .clr(load),
    .p_lat(p_lat_q), .pg_last(eoc)
  );

  always_comb begin
    load    = boot_q || eoc;
    p_lat_d = load ? prog_p : p_lat_q;
    s_lat_d = load ? swal_s : s_lat_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      boot_q  <= 1'b1;
      pulse_q <= 1'b0;
      p_lat_q <= '0;
      s_lat_q <= '0;
    end else begin
      boot_q  <= 1'b0;
      pulse_q <= eoc;
      p_lat_q <= p_lat_d;
      s_lat_q <= s_lat_d;
    end
  end

  assign div_pulse = pulse_q;
  assign mod_ctrl  = (mod_sel == MOD_PLUS);
  assign cfg_err   = (swal_s > prog_p) || (prog_p == '0);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    div_pulse |=> !div_pulse);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !($stable(p_lat_q) && $stable(s_lat_q)) |-> $past(load));

  // R3
  mod_fall_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(mod_ctrl) |-> $past(pre_tick));

  // R3
  mod_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(mod_ctrl) |-> $past(load));
endmodule

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;
  localparam int W = 6;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] p_in;
  logic [W-1:0] s_in;
  logic         pulse4, mod4, err4;
  logic         pulse2, mod2, err2;

  int checks;
  int errors;

  typedef struct packed {
    logic         sel;
    logic [W-1:0] p;
    logic [W-1:0] s;
    int           n;
    int           mh;
    logic         err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS[NV] = '{
    '{1'b0, 6'd3,  6'd0,  12,  0,   1'b0},
    '{1'b0, 6'd3,  6'd3,  15,  15,  1'b0},
    '{1'b0, 6'd5,  6'd2,  22,  10,  1'b0},
    '{1'b0, 6'd1,  6'd0,  4,   0,   1'b0},
    '{1'b0, 6'd1,  6'd1,  5,   5,   1'b0},
    '{1'b0, 6'd6,  6'd4,  28,  20,  1'b0},
    '{1'b0, 6'd10, 6'd7,  47,  35,  1'b0},
    '{1'b0, 6'd2,  6'd5,  10,  10,  1'b1},
    '{1'b0, 6'd63, 6'd63, 315, 315, 1'b0},
    '{1'b1, 6'd6,  6'd4,  16,  12,  1'b0},
    '{1'b1, 6'd1,  6'd1,  3,   3,   1'b0},
    '{1'b1, 6'd3,  6'd0,  6,   0,   1'b0},
    '{1'b1, 6'd2,  6'd2,  6,   6,   1'b0},
    '{1'b1, 6'd1,  6'd3,  3,   3,   1'b1}
  };

  pswallow_div #(.M(4), .CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_p(p_in), .swal_s(s_in),
    .div_pulse(pulse4), .mod_ctrl(mod4), .cfg_err(err4)
  );

  pswallow_div #(.M(2), .CNT_W(W)) u_dut_m2 (
    .clk(clk), .rst_n(rst_n), .prog_p(p_in), .swal_s(s_in),
    .div_pulse(pulse2), .mod_ctrl(mod2), .cfg_err(err2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick_pulse(input logic sel);
    return sel ? pulse2 : pulse4;
  endfunction

  function automatic logic pick_mod(input logic sel);
    return sel ? mod2 : mod4;
  endfunction

  // Called at a negedge. With sync set, waits for the next pulse first.
  // Returns the interval to the next pulse, the mod_ctrl-high count
  // within it, and the width of the starting pulse.
  task automatic measure(input logic sel, input logic sync,
                         output int period, output int modhi, output int width);
    int guard;
    guard = 0;
    if (sync) begin
      do begin
        @(negedge clk);
        guard++;
      end while (!pick_pulse(sel) && guard < 2000);
    end
    period = 0;
    modhi  = 0;
    width  = 0;
    do begin
      if (pick_mod(sel)) modhi++;
      if (pick_pulse(sel) && period == width) width++;
      @(negedge clk);
      period++;
    end while (!pick_pulse(sel) && period < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, mh, wd;
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    p_in   = 6'd3;
    s_in   = 6'd2;
    repeat (5) @(negedge clk);
    // R1 reset state
    check_eq("R1 div_pulse in reset (M=4)", int'(pulse4), 0);
    check_eq("R1 mod_ctrl in reset (M=4)", int'(mod4), 0);
    check_eq("R1 div_pulse in reset (M=2)", int'(pulse2), 0);
    check_eq("R1 mod_ctrl in reset (M=2)", int'(mod2), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      p_in = VECS[i].p;
      s_in = VECS[i].s;
      #1;
      check_eq("R7 cfg_err", int'(VECS[i].sel ? err2 : err4), int'(VECS[i].err));
      measure(VECS[i].sel, 1'b1, per, mh, wd);
      if (VECS[i].err) begin
        check_eq("R8 period when S>P", per, VECS[i].n);
        check_eq("R8 mod_ctrl high count when S>P", mh, VECS[i].mh);
      end else begin
        check_eq("R2 R4 period", per, VECS[i].n);
        check_eq("R3 mod_ctrl high count", mh, VECS[i].mh);
      end
      check_eq("R5 pulse width", wd, 1);
    end

    // R7 zero program count
    @(negedge clk);
    p_in = 6'd0;
    s_in = 6'd0;
    #1;
    check_eq("R7 cfg_err for P=0", int'(err4), 1);
    p_in = 6'd4;
    s_in = 6'd4;
    #1;
    check_eq("R7 cfg_err for S=P", int'(err4), 0);

    // R9 continuity from M*(M-1)
    for (int n = 12; n < 20; n++) begin
      @(negedge clk);
      p_in = W'(n / 4);
      s_in = W'(n % 4);
      measure(1'b0, 1'b1, per, mh, wd);
      check_eq("R9 continuous ratio M=4", per, n);
    end
    for (int n = 2; n < 10; n++) begin
      @(negedge clk);
      p_in = W'(n / 2);
      s_in = W'(n % 2);
      measure(1'b1, 1'b1, per, mh, wd);
      check_eq("R9 continuous ratio M=2", per, n);
    end

    // R6 change right after a pulse: old ratio finishes, then new one
    @(negedge clk);
    p_in = 6'd3;
    s_in = 6'd0;
    measure(1'b0, 1'b1, per, mh, wd);
    p_in = 6'd5;
    s_in = 6'd2;
    measure(1'b0, 1'b0, per, mh, wd);
    check_eq("R6 running period keeps old ratio", per, 12);
    measure(1'b0, 1'b0, per, mh, wd);
    check_eq("R6 next period uses new ratio", per, 22);
    check_eq("R6 next mod_ctrl high count", mh, 10);

    // R6 mid-period change ignored
    repeat (5) @(negedge clk);
    p_in = 6'd2;
    s_in = 6'd1;
    measure(1'b0, 1'b0, per, mh, wd);
    check_eq("R6 remainder after mid-period change", per, 17);
    measure(1'b0, 1'b0, per, mh, wd);
    check_eq("R6 period after mid-period change", per, 9);

    // R1 reset in mid-run with mod_ctrl high
    p_in = 6'd6;
    s_in = 6'd6;
    measure(1'b0, 1'b1, per, mh, wd);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R1 mod_ctrl cleared by reset", int'(mod4), 0);
    check_eq("R1 div_pulse cleared by reset", int'(pulse4), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    measure(1'b0, 1'b1, per, mh, wd);
    check_eq("R2 R4 period after reset", per, 30);
    check_eq("R3 mod_ctrl high after reset", mh, 30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule